// File: doc/BRIEF.md
# Vector-Extension Prefix Decoder

This block sits in an instruction-fetch path and takes instruction bytes one per cycle over a valid/ready handshake. It detects the two-byte and three-byte vector-extension prefix forms and expands them into a decoded descriptor. The descriptor carries:

- the register-extension bits R, X and B;
- the operand-width bit W;
- the extra source register index (vvvv);
- the vector length bit;
- the implied legacy prefix code;
- the opcode map, together with the opcode byte that follows the prefix.

The lead bytes 0xC5 (two-byte form) and 0xC4 (three-byte form) also encode legacy segment-load opcodes. The block chooses between the two readings from the processor mode and from the top two bits of the byte after the lead. It flags encodings that are illegal.

Upstream logic pulses `start` at the beginning of each instruction. It then streams the bytes that follow any legacy prefixes, and supplies two flags: one saying that an operand-size, REP, REPNE or LOCK prefix was already seen, and one saying that a REX prefix was seen.

The block produces exactly one descriptor per instruction. The descriptor is marked by a one-cycle `d_valid` strobe. After that the block accepts no more bytes until the next `start`.

The controller is a state machine with six states:

| State | Meaning |
|---|---|
| LEAD | Waiting for the first byte |
| SEC_SHORT | Second byte of the two-byte form |
| SEC_LONG | Second byte of the three-byte form |
| THIRD | Third byte of the three-byte form |
| OPCODE | Opcode byte after the prefix |
| DONE | Descriptor issued; waiting for `start` |

Its transitions are:

- LEAD to SEC_SHORT or SEC_LONG on an accepted lead byte while prefixes are enabled.
- LEAD to DONE on any other byte.
- SEC_SHORT to OPCODE on an accepted second byte.
- SEC_LONG to THIRD on an accepted second byte.
- SEC_SHORT or SEC_LONG to DONE on an illegal prefix, or when the byte is refused as a legacy load.
- THIRD to OPCODE on a valid map.
- THIRD to DONE on an invalid map.
- OPCODE to DONE.
- Any state to LEAD on `start`.

Top module: `vexpfx_decoder`

## Requirements
- R1: Reset and `start` clear every descriptor output to zero. `d_valid` is low in the following cycle, and `in_ready` is low in any cycle in which `start` is high.
- R2: A first byte other than 0xC5 or 0xC4 is passed on as a plain descriptor with `d_vex`=0, `d_map`=0, `d_opcode` equal to that byte and all other fields 0. The same applies to 0xC5 or 0xC4 when `mode_code32`=0 or `mode_v86`=1.
- R3: Outside long mode (`mode_long`=0), after an enabled 0xC5 or 0xC4 lead, a next byte whose bits [7:6] are not both 1 is refused (`in_ready`=0). A plain descriptor is then issued with `d_opcode` set to the lead byte. In long mode that byte is always accepted as the second prefix byte.
- R4: When the second prefix byte is accepted while `pfx_legacy_seen` or `pfx_rex_seen` is 1, an illegal descriptor is issued: `d_vex`=1, `d_illegal`=1, and all other fields 0.
- R5: The two-byte form sets R = NOT bit 7 of byte 2, `d_vvvv` = NOT bits [6:3], `d_len` = bit 2 and `d_pp` = bits [1:0]. The implied-prefix code is 0 for none, 1 for 0x66, 2 for 0xF3 and 3 for 0xF2. The form also sets `d_map`=1 and W=X=B=0.
- R6: The three-byte form sets R, X and B to NOT bits 7, 6 and 5 of byte 2, and W to bit 7 of byte 3. It sets `d_vvvv`, `d_len` and `d_pp` from bits [6:3] (inverted), bit 2 and bits [1:0] of byte 3.
- R7: In the three-byte form, bits [4:0] of byte 2 select the map: values 1, 2 and 3 give `d_map` 1 (0F), 2 (0F 38) and 3 (0F 3A). Any other value gives the illegal descriptor of R4 when byte 3 is accepted.
- R8: After a complete legal prefix, the next accepted byte is issued as `d_opcode` with `d_vex`=1 and `d_illegal`=0.
- R9: Every descriptor appears in the cycle after the clock edge that decides it. `d_valid` is high for exactly one cycle, and `in_ready` stays low from then until the next `start`.
- R10: A cycle with `in_valid`=0 and no `start` leaves the decode progress unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start-of-instruction pulse |
| mode_code32 | input | 1 | 32-bit code segment flag |
| mode_v86 | input | 1 | Virtual-8086 mode flag |
| mode_long | input | 1 | 64-bit mode flag |
| pfx_legacy_seen | input | 1 | Operand-size, REP, REPNE or LOCK prefix already seen |
| pfx_rex_seen | input | 1 | REX prefix already seen |
| in_valid | input | 1 | Byte available |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted this cycle when `in_valid` is high |
| d_valid | output | 1 | Descriptor strobe, one cycle |
| d_map | output | 2 | Opcode map: 0 legacy, 1 0F, 2 0F 38, 3 0F 3A |
| d_opcode | output | 8 | Opcode byte |
| d_r | output | 1 | R extension |
| d_x | output | 1 | X extension |
| d_b | output | 1 | B extension |
| d_w | output | 1 | Operand-width bit |
| d_vvvv | output | 4 | Extra register index, already un-inverted |
| d_len | output | 1 | Vector length bit |
| d_pp | output | 2 | Implied legacy prefix code |
| d_vex | output | 1 | Prefix present |
| d_illegal | output | 1 | Illegal encoding |

## Verification
`in_ready` is combinational: it depends on the current state, `start`, the mode and bits [7:6] of the presented byte. The bench therefore checks it in the same cycle the byte is offered.

Every descriptor is registered. It is due in the cycle after the edge that accepts the deciding byte, or after the edge at which a legacy-load second byte is refused. The bench's behavioural model advances at each rising edge from the inputs it applied. The bench then compares `d_valid`, `in_ready` and, when a strobe or a clear is due, every field, at mid-cycle after that edge. This keeps each comparison exactly one register stage behind its stimulus.

// File: rtl/vexpfx_pkg.sv
package vexpfx_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned REG_W    = 4;
    localparam int unsigned REG_LO   = 3;
    localparam int unsigned LEN_BIT  = 2;
    localparam int unsigned PP_W     = 2;
    localparam int unsigned MAP_W    = 2;
    localparam int unsigned SEL_W    = 5;
    localparam int unsigned MAP_LAST = 3;

    typedef enum logic [2:0] {
        S_LEAD,
        S_SEC_SHORT,
        S_SEC_LONG,
        S_THIRD,
        S_OPCODE,
        S_DONE
    } state_t;

    typedef enum logic [3:0] {
        A_NONE,
        A_CLEAR,
        A_LEAD_HOLD,
        A_EMIT_PLAIN,
        A_EMIT_HELD,
        A_TAKE_SHORT,
        A_TAKE_LONG2,
        A_TAKE_LONG3,
        A_EMIT_OPC,
        A_EMIT_BAD
    } act_t;

    typedef struct packed {
        logic [MAP_W-1:0]  map;
        logic [BYTE_W-1:0] opcode;
        logic              r;
        logic              x;
        logic              b;
        logic              w;
        logic [REG_W-1:0]  vvvv;
        logic              len;
        logic [PP_W-1:0]   pp;
        logic              vex;
        logic              illegal;
        logic              map_ok;
    } desc_t;

endpackage

// File: rtl/vexpfx_fields.sv
module vexpfx_fields
    import vexpfx_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output logic              f_r,
    output logic              f_x,
    output logic              f_b,
    output logic              f_w,
    output logic [REG_W-1:0]  f_vvvv,
    output logic              f_len,
    output logic [PP_W-1:0]   f_pp,
    output logic [MAP_W-1:0]  f_map,
    output logic              f_map_ok
);

    localparam int unsigned TOP = BYTE_W - 1;

    logic [SEL_W-1:0] sel;

    assign f_r = ~byte_in[TOP];
    assign f_x = ~byte_in[TOP-1];
    assign f_b = ~byte_in[TOP-2];
    assign f_w =  byte_in[TOP];

    // The register index is stored complemented, one bit at a time.
    for (genvar g = 0; g < REG_W; g++) begin : g_vvvv
        assign f_vvvv[g] = ~byte_in[REG_LO+g];
    end

    assign f_len    = byte_in[LEN_BIT];
    assign f_pp     = byte_in[PP_W-1:0];
    assign sel      = byte_in[SEL_W-1:0];
    assign f_map    = sel[MAP_W-1:0];
    assign f_map_ok = (sel != '0) && (sel <= SEL_W'(MAP_LAST));

endmodule

// File: rtl/vexpfx_fsm.sv
module vexpfx_fsm
    import vexpfx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] LEAD_SHORT = 8'hC5,
    parameter logic [BYTE_W-1:0] LEAD_LONG  = 8'hC4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode_code32,
    input  logic              mode_v86,
    input  logic              mode_long,
    input  logic              pfx_legacy_seen,
    input  logic              pfx_rex_seen,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              map_ok,
    output logic              in_ready,
    output act_t              act
);

    localparam int unsigned TOP = BYTE_W - 1;

    state_t state, state_nx;
    logic   top_pair_set, is_short, is_long, pfx_enabled, early_pfx;

    assign top_pair_set = in_data[TOP] & in_data[TOP-1];
    assign is_short     = (in_data == LEAD_SHORT);
    assign is_long      = (in_data == LEAD_LONG);
    assign pfx_enabled  = mode_code32 & ~mode_v86;
    assign early_pfx    = pfx_legacy_seen | pfx_rex_seen;

    always_ff @(posedge clk) begin
        if (rst) state <= S_LEAD;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        act      = A_NONE;
        in_ready = 1'b0;
        if (start) begin
            act      = A_CLEAR;
            state_nx = S_LEAD;
        end else begin
            unique case (state)
                S_LEAD: begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        if (pfx_enabled && (is_short || is_long)) begin
                            act      = A_LEAD_HOLD;
                            state_nx = is_short ? S_SEC_SHORT : S_SEC_LONG;
                        end else begin
                            act      = A_EMIT_PLAIN;
                            state_nx = S_DONE;
                        end
                    end
                end
                S_SEC_SHORT, S_SEC_LONG: begin
                    in_ready = mode_long | top_pair_set;
                    if (in_valid) begin
                        if (!in_ready) begin
                            act      = A_EMIT_HELD;
                            state_nx = S_DONE;
                        end else if (early_pfx) begin
                            act      = A_EMIT_BAD;
                            state_nx = S_DONE;
                        end else if (state == S_SEC_SHORT) begin
                            act      = A_TAKE_SHORT;
                            state_nx = S_OPCODE;
                        end else begin
                            act      = A_TAKE_LONG2;
                            state_nx = S_THIRD;
                        end
                    end
                end
                S_THIRD: begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        act      = map_ok ? A_TAKE_LONG3 : A_EMIT_BAD;
                        state_nx = map_ok ? S_OPCODE : S_DONE;
                    end
                end
                S_OPCODE: begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        act      = A_EMIT_OPC;
                        state_nx = S_DONE;
                    end
                end
                S_DONE: begin
                    in_ready = 1'b0;
                end
                default: state_nx = S_LEAD;
            endcase
        end
    end

    // A refused second byte outside long mode ends the instruction (R3).
    p_peek_done_r3: assert property (@(posedge clk) disable iff (rst)
        ((state == S_SEC_SHORT || state == S_SEC_LONG) && in_valid && !start
         && !mode_long && !(in_data[TOP] && in_data[TOP-1]))
        |=> (state == S_DONE));

    // Idle input cycles keep the decode progress (R10).
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !start) |=> $stable(state));

endmodule

// File: rtl/vexpfx_desc.sv
module vexpfx_desc
    import vexpfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  act_t              act,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              f_r,
    input  logic              f_x,
    input  logic              f_b,
    input  logic              f_w,
    input  logic [REG_W-1:0]  f_vvvv,
    input  logic              f_len,
    input  logic [PP_W-1:0]   f_pp,
    input  logic [MAP_W-1:0]  f_map,
    input  logic              f_map_ok,
    output desc_t             desc,
    output logic              d_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            desc    <= '0;
            d_valid <= 1'b0;
        end else begin
            d_valid <= 1'b0;
            unique case (act)
                A_NONE: ;
                A_CLEAR: desc <= '0;
                A_LEAD_HOLD: desc.opcode <= in_data;
                A_EMIT_PLAIN: begin
                    desc.opcode <= in_data;
                    d_valid     <= 1'b1;
                end
                A_EMIT_HELD: d_valid <= 1'b1;
                A_TAKE_SHORT: begin
                    desc.r    <= f_r;
                    desc.vvvv <= f_vvvv;
                    desc.len  <= f_len;
                    desc.pp   <= f_pp;
                    desc.map  <= MAP_W'(1);
                end
                A_TAKE_LONG2: begin
                    desc.r      <= f_r;
                    desc.x      <= f_x;
                    desc.b      <= f_b;
                    desc.map    <= f_map;
                    desc.map_ok <= f_map_ok;
                end
                A_TAKE_LONG3: begin
                    desc.w    <= f_w;
                    desc.vvvv <= f_vvvv;
                    desc.len  <= f_len;
                    desc.pp   <= f_pp;
                end
                A_EMIT_OPC: begin
                    desc.opcode <= in_data;
                    desc.vex    <= 1'b1;
                    d_valid     <= 1'b1;
                end
                A_EMIT_BAD: begin
                    desc         <= '0;
                    desc.vex     <= 1'b1;
                    desc.illegal <= 1'b1;
                    d_valid      <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    p_start_clears_r1: assert property (@(posedge clk) disable iff (rst)
        start |=> (!d_valid && desc.opcode == '0 && !desc.vex && !desc.illegal
                   && desc.map == '0 && desc.vvvv == '0 && desc.pp == '0));

    p_plain_shape_r2: assert property (@(posedge clk) disable iff (rst)
        (d_valid && !desc.vex) |-> (desc.map == '0 && desc.vvvv == '0 && !desc.r
            && !desc.x && !desc.b && !desc.w && !desc.len && desc.pp == '0
            && !desc.illegal));

    p_illegal_shape_r4: assert property (@(posedge clk) disable iff (rst)
        (d_valid && desc.illegal) |-> (desc.vex && desc.map == '0
            && desc.opcode == '0 && desc.vvvv == '0 && !desc.r && !desc.w));

    p_map_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        (d_valid && desc.vex && !desc.illegal) |-> (desc.map != '0));

    p_single_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        d_valid |=> !d_valid);

endmodule

// File: rtl/vexpfx_decoder.sv
module vexpfx_decoder
    import vexpfx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] LEAD_SHORT = 8'hC5,
    parameter logic [BYTE_W-1:0] LEAD_LONG  = 8'hC4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode_code32,
    input  logic              mode_v86,
    input  logic              mode_long,
    input  logic              pfx_legacy_seen,
    input  logic              pfx_rex_seen,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              d_valid,
    output logic [MAP_W-1:0]  d_map,
    output logic [BYTE_W-1:0] d_opcode,
    output logic              d_r,
    output logic              d_x,
    output logic              d_b,
    output logic              d_w,
    output logic [REG_W-1:0]  d_vvvv,
    output logic              d_len,
    output logic [PP_W-1:0]   d_pp,
    output logic              d_vex,
    output logic              d_illegal
);

    act_t             act;
    desc_t            desc;
    logic             f_r, f_x, f_b, f_w, f_len, f_map_ok;
    logic [REG_W-1:0] f_vvvv;
    logic [PP_W-1:0]  f_pp;
    logic [MAP_W-1:0] f_map;

    vexpfx_fsm #(
        .LEAD_SHORT (LEAD_SHORT),
        .LEAD_LONG  (LEAD_LONG)
    ) u_fsm (
        .clk             (clk),
        .rst             (rst),
        .start           (start),
        .mode_code32     (mode_code32),
        .mode_v86        (mode_v86),
        .mode_long       (mode_long),
        .pfx_legacy_seen (pfx_legacy_seen),
        .pfx_rex_seen    (pfx_rex_seen),
        .in_valid        (in_valid),
        .in_data         (in_data),
        .map_ok          (desc.map_ok),
        .in_ready        (in_ready),
        .act             (act)
    );

    vexpfx_fields u_fields (
        .byte_in  (in_data),
        .f_r      (f_r),
        .f_x      (f_x),
        .f_b      (f_b),
        .f_w      (f_w),
        .f_vvvv   (f_vvvv),
        .f_len    (f_len),
        .f_pp     (f_pp),
        .f_map    (f_map),
        .f_map_ok (f_map_ok)
    );

    vexpfx_desc u_desc (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .act      (act),
        .in_data  (in_data),
        .f_r      (f_r),
        .f_x      (f_x),
        .f_b      (f_b),
        .f_w      (f_w),
        .f_vvvv   (f_vvvv),
        .f_len    (f_len),
        .f_pp     (f_pp),
        .f_map    (f_map),
        .f_map_ok (f_map_ok),
        .desc     (desc),
        .d_valid  (d_valid)
    );

    assign d_map     = desc.map;
    assign d_opcode  = desc.opcode;
    assign d_r       = desc.r;
    assign d_x       = desc.x;
    assign d_b       = desc.b;
    assign d_w       = desc.w;
    assign d_vvvv    = desc.vvvv;
    assign d_len     = desc.len;
    assign d_pp      = desc.pp;
    assign d_vex     = desc.vex;
    assign d_illegal = desc.illegal;

    // No byte is taken after a descriptor until the next start (R9).
    p_quiet_after_r9: assert property (@(posedge clk) disable iff (rst)
        (d_valid && !start) |-> !in_ready);

endmodule

// File: tb/vexpfx_decoder_bench.sv
`timescale 1ns/1ps
module vexpfx_decoder_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       mode_code32 = 1'b0, mode_v86 = 1'b0, mode_long = 1'b0;
    logic       pfx_legacy_seen = 1'b0, pfx_rex_seen = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, d_valid, d_r, d_x, d_b, d_w, d_len, d_vex, d_illegal;
    logic [1:0] d_map, d_pp;
    logic [7:0] d_opcode;
    logic [3:0] d_vvvv;

    always #4 clk = ~clk;

    vexpfx_decoder u_vexpfx_decoder (
        .clk(clk), .rst(rst), .start(start), .mode_code32(mode_code32),
        .mode_v86(mode_v86), .mode_long(mode_long),
        .pfx_legacy_seen(pfx_legacy_seen), .pfx_rex_seen(pfx_rex_seen),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .d_valid(d_valid), .d_map(d_map), .d_opcode(d_opcode), .d_r(d_r),
        .d_x(d_x), .d_b(d_b), .d_w(d_w), .d_vvvv(d_vvvv), .d_len(d_len),
        .d_pp(d_pp), .d_vex(d_vex), .d_illegal(d_illegal)
    );

    int    n_chk = 0, n_bad = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // Behavioural reference: phase 0 first byte, 1 short second, 2 long
    // second, 3 third, 4 opcode, 5 finished.
    int         ph = 0;
    logic [7:0] lead, b2, b3;
    bit         m_valid = 0, m_zchk = 0;
    logic [7:0] e_opc;
    logic [1:0] e_map, e_pp;
    logic [3:0] e_vvvv;
    bit         e_r, e_x, e_b, e_w, e_len, e_vex, e_ill;

    function automatic bit model_ready();
        if (start) return 0;
        case (ph)
            0, 3, 4: return 1;
            1, 2:    return mode_long || (in_data[7:6] == 2'b11);
            default: return 0;
        endcase
    endfunction

    task automatic zero_exp();
        e_opc = 0; e_map = 0; e_pp = 0; e_vvvv = 0;
        e_r = 0; e_x = 0; e_b = 0; e_w = 0; e_len = 0; e_vex = 0; e_ill = 0;
    endtask

    always @(posedge clk) begin
        m_valid = 0;
        m_zchk  = 0;
        if (rst || start) begin
            ph = 0; zero_exp(); m_zchk = 1;
        end else if (in_valid) begin
            case (ph)
                0: begin
                    if (mode_code32 && !mode_v86 && (in_data == 8'hC5 || in_data == 8'hC4)) begin
                        lead = in_data; ph = (in_data == 8'hC5) ? 1 : 2;
                    end else begin
                        zero_exp(); e_opc = in_data; m_valid = 1; ph = 5;
                    end
                end
                1, 2: begin
                    if (!mode_long && in_data[7:6] != 2'b11) begin
                        zero_exp(); e_opc = lead; m_valid = 1; ph = 5;
                    end else if (pfx_legacy_seen || pfx_rex_seen) begin
                        zero_exp(); e_vex = 1; e_ill = 1; m_valid = 1; ph = 5;
                    end else begin
                        b2 = in_data; ph = (ph == 1) ? 4 : 3;
                    end
                end
                3: begin
                    b3 = in_data;
                    if (b2[4:0] < 5'd1 || b2[4:0] > 5'd3) begin
                        zero_exp(); e_vex = 1; e_ill = 1; m_valid = 1; ph = 5;
                    end else ph = 4;
                end
                4: begin
                    zero_exp();
                    e_r = !b2[7];
                    if (lead == 8'hC5) begin
                        e_map = 1; e_vvvv = ~b2[6:3]; e_len = b2[2]; e_pp = b2[1:0];
                    end else begin
                        e_x = !b2[6]; e_b = !b2[5]; e_map = b2[1:0];
                        e_w = b3[7]; e_vvvv = ~b3[6:3]; e_len = b3[2]; e_pp = b3[1:0];
                    end
                    e_opc = in_data; e_vex = 1; m_valid = 1; ph = 5;
                end
                default: ;
            endcase
        end
    end

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (!rst && !finished) begin
            check(d_valid === m_valid, "d_valid", 32'(d_valid), 32'(m_valid));
            check(in_ready === model_ready(), "in_ready", 32'(in_ready), 32'(model_ready()));
            if (m_valid || m_zchk) begin
                check({d_map, d_opcode, d_r, d_x, d_b, d_w, d_vvvv, d_len, d_pp, d_vex, d_illegal}
                      === {e_map, e_opc, e_r, e_x, e_b, e_w, e_vvvv, e_len, e_pp, e_vex, e_ill},
                      "descriptor",
                      32'({d_map, d_opcode, d_r, d_x, d_b, d_w, d_vvvv, d_len, d_pp, d_vex, d_illegal}),
                      32'({e_map, e_opc, e_r, e_x, e_b, e_w, e_vvvv, e_len, e_pp, e_vex, e_ill}));
            end
        end
    end

    task automatic offer(input logic [7:0] b);
        bit acc;
        in_valid = 1; in_data = b;
        for (int k = 0; k < 3; k++) begin
            #3; acc = in_ready;
            @(negedge clk);
            if (acc) break;
        end
        in_valid = 0;
    endtask

    task automatic instr(input string req, input bit c32, input bit v86, input bit lng,
                         input bit leg, input bit rex, input int n,
                         input logic [7:0] x0, input logic [7:0] x1,
                         input logic [7:0] x2, input logic [7:0] x3, input int gap);
        logic [7:0] bs [4];
        bs[0] = x0; bs[1] = x1; bs[2] = x2; bs[3] = x3;
        cur_req = req;
        mode_code32 = c32; mode_v86 = v86; mode_long = lng;
        pfx_legacy_seen = leg; pfx_rex_seen = rex;
        start = 1; in_valid = 0;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < n; i++) begin
            offer(bs[i]);
            repeat (gap) @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        instr("R1", 1, 0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        instr("R2", 1, 0, 0, 0, 0, 1, 8'h90, 8'h00, 8'h00, 8'h00, 0);
        instr("R2", 0, 0, 0, 0, 0, 2, 8'hC4, 8'hE2, 8'h00, 8'h00, 0);
        instr("R2", 1, 1, 0, 0, 0, 2, 8'hC5, 8'hF8, 8'h00, 8'h00, 0);
        instr("R3", 1, 0, 0, 0, 0, 3, 8'hC5, 8'h3F, 8'h58, 8'h00, 0);
        instr("R3", 1, 0, 0, 0, 0, 3, 8'hC4, 8'h7F, 8'h10, 8'h00, 0);
        instr("R3", 1, 0, 0, 1, 0, 2, 8'hC5, 8'h3F, 8'h00, 8'h00, 0);
        instr("R3", 1, 0, 1, 0, 0, 3, 8'hC5, 8'h3F, 8'h58, 8'h00, 0);
        instr("R4", 1, 0, 0, 1, 0, 3, 8'hC5, 8'hF8, 8'h10, 8'h00, 0);
        instr("R4", 1, 0, 1, 0, 1, 4, 8'hC4, 8'hE1, 8'h79, 8'h18, 0);
        instr("R5", 1, 0, 0, 0, 0, 3, 8'hC5, 8'hF8, 8'h10, 8'h00, 0);
        instr("R5", 1, 0, 0, 0, 0, 3, 8'hC5, 8'hFD, 8'h6F, 8'h00, 0);
        instr("R5", 1, 0, 0, 0, 0, 3, 8'hC5, 8'hCA, 8'h58, 8'h00, 0);
        instr("R6", 1, 0, 0, 0, 0, 4, 8'hC4, 8'hE2, 8'h79, 8'h18, 0);
        instr("R6", 1, 0, 1, 0, 0, 4, 8'hC4, 8'h03, 8'hC5, 8'h0F, 0);
        instr("R7", 1, 0, 0, 0, 0, 4, 8'hC4, 8'hE1, 8'hFB, 8'h2A, 0);
        instr("R7", 1, 0, 0, 0, 0, 4, 8'hC4, 8'hE0, 8'h7C, 8'h00, 0);
        instr("R7", 1, 0, 0, 0, 0, 4, 8'hC4, 8'hE4, 8'h7C, 8'h00, 0);
        instr("R7", 1, 0, 0, 0, 0, 4, 8'hC4, 8'hFF, 8'h7C, 8'h00, 0);
        instr("R8", 1, 0, 1, 0, 0, 3, 8'hC5, 8'h78, 8'hC2, 8'h00, 0);
        instr("R9", 1, 0, 0, 0, 0, 4, 8'hC5, 8'hF8, 8'h10, 8'h90, 0);
        instr("R10", 1, 0, 0, 0, 0, 4, 8'hC4, 8'hE2, 8'h79, 8'h18, 2);
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL %s watchdog: actual=hung expected=finished", cur_req);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule